// File: doc/BRIEF.md
# 100BASE-TX Receive Carrier and Framing Detector

This block sits behind the code-group aligner of a 100 Mb/s receive path. Each cycle of a 25 MHz clock it accepts one aligned 5-bit code group and drives the receive side of a nibble-wide media independent interface: carrier sense, data valid, a 4-bit data nibble and an error flag. It also drives a collision indication, which is used only in half-duplex operation.

A frame begins on the start-of-stream pair, a J group followed by a K group. The two groups of that pair are delivered as the nibble 0x5 twice, so the preamble reaches the MAC unchanged. Data groups are then decoded to nibbles. A frame closes on the end-of-stream pair, a T group followed by an R group. It also closes, with an error, when idle groups arrive before any T/R pair. A code group that is not valid inside a frame is delivered as an error nibble.

The decision for each code group uses the group that follows it. The outputs for the group sampled at rising edge n therefore change at rising edge n+1.

Top module: `rx_frame_det`

## Requirements
- R1: While `rst` is high, and after a reset, `rx_dv`, `rx_er`, `crs`, `col` and `rxd` are all 0.
- R2: A J group (5'b11000) followed by a K group (5'b10001) starts a frame. The output slot of the J group and the output slot of the K group each show `rx_dv`=1, `crs`=1 and `rxd`=0x5. Every output slot appears one rising edge after the edge that samples its code group.
- R3: Inside a frame, a data group is presented as its nibble with `rx_dv`=1 and `rx_er`=0. The data groups are, for nibbles 0 to F in order: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R4: Inside a frame, a T group (5'b01101) followed by an R group (5'b00111) ends the frame. The slots of both T and R show `rx_dv`=0 and `crs`=0.
- R5: Inside a frame, when the next group is IDLE (5'b11111) without a T/R pair, the current slot is still delivered with `rx_dv`=1 but `rx_er`=1, and the following slots show `rx_dv`=0 and `crs`=0. This includes the K slot.
- R6: Inside a frame, any group other than a data group is shown as `rxd`=0xE with `rx_er`=1 for that slot only, and the frame continues. This covers J, K, R, a T not followed by R, and unused codes.
- R7: Outside a frame, data groups, lone J groups and other groups are ignored: `rx_dv` and `crs` stay 0.
- R8: `col` is 1 exactly when `half_duplex`, `tx_active` and `crs` are all 1.
- R9: Whenever `rx_dv` is 0, `rxd` is 0 and `rx_er` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz receive clock |
| rst | input | 1 | Synchronous reset, active high |
| code_in | input | 5 | Aligned code group, one per cycle |
| half_duplex | input | 1 | 1 selects half-duplex operation |
| tx_active | input | 1 | Local transmitter is sending |
| rx_dv | output | 1 | Receive data valid |
| rxd | output | 4 | Receive data nibble |
| rx_er | output | 1 | Receive error flag |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision indication |

## Verification
Two error causes can land on the same output slot. One is an invalid code group, which forces the error nibble. The other is the idle abort, which flags the slot just before the idle group. The bench provokes this with the sequence J, K, an unused code, then IDLE. It expects exactly one slot with `rxd`=0xE and `rx_er`=1, followed directly by `rx_dv` and `crs` low.

A second overlap happens when carrier falls on the T slot while `tx_active` is held high in half duplex. There the bench expects `col` to fall in the same slot as `crs`.

// File: rtl/rx_frame_pkg.sv
package rx_frame_pkg;

    localparam int CG_W  = 5;
    localparam int NIB_W = 4;

    localparam logic [CG_W-1:0] CG_J    = 5'b11000;
    localparam logic [CG_W-1:0] CG_K    = 5'b10001;
    localparam logic [CG_W-1:0] CG_T    = 5'b01101;
    localparam logic [CG_W-1:0] CG_R    = 5'b00111;
    localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;

    localparam logic [NIB_W-1:0] NIB_PRE = 4'h5;
    localparam logic [NIB_W-1:0] NIB_BAD = 4'hE;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SSD2 = 2'd1,
        ST_DATA = 2'd2
    } rx_state_t;

    typedef struct packed {
        logic             dv;
        logic             er;
        logic             crs;
        logic [NIB_W-1:0] nib;
    } rx_slot_t;

    typedef struct packed {
        logic             valid;
        logic [NIB_W-1:0] nib;
    } dec_t;

    function automatic dec_t decode_cg(input logic [CG_W-1:0] cg);
        dec_t d;
        d.valid = 1'b1;
        case (cg)
            5'b11110: d.nib = 4'h0;
            5'b01001: d.nib = 4'h1;
            5'b10100: d.nib = 4'h2;
            5'b10101: d.nib = 4'h3;
            5'b01010: d.nib = 4'h4;
            5'b01011: d.nib = 4'h5;
            5'b01110: d.nib = 4'h6;
            5'b01111: d.nib = 4'h7;
            5'b10010: d.nib = 4'h8;
            5'b10011: d.nib = 4'h9;
            5'b10110: d.nib = 4'hA;
            5'b10111: d.nib = 4'hB;
            5'b11010: d.nib = 4'hC;
            5'b11011: d.nib = 4'hD;
            5'b11100: d.nib = 4'hE;
            5'b11101: d.nib = 4'hF;
            default: begin
                d.valid = 1'b0;
                d.nib   = NIB_BAD;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rx_cg_window.sv
module rx_cg_window
    import rx_frame_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [CG_W-1:0] code_in,
    output logic [CG_W-1:0] cg_cur,
    output logic            pair_jk,
    output logic            pair_tr,
    output logic            idle_next
);
    logic [CG_W-1:0] cg_q;

    always_ff @(posedge clk) begin
        if (rst) cg_q <= CG_IDLE;
        else     cg_q <= code_in;
    end

    assign cg_cur    = cg_q;
    assign pair_jk   = (cg_q == CG_J) && (code_in == CG_K);
    assign pair_tr   = (cg_q == CG_T) && (code_in == CG_R);
    assign idle_next = (code_in == CG_IDLE);

    a_r4_pairs_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(pair_jk && pair_tr));
endmodule

// File: rtl/rx_cg_decode.sv
module rx_cg_decode
    import rx_frame_pkg::*;
(
    input  logic [CG_W-1:0]  cg,
    output logic             is_data,
    output logic [NIB_W-1:0] nib
);
    dec_t d;

    always_comb begin
        d       = decode_cg(cg);
        is_data = d.valid;
        nib     = d.nib;
    end

    always_comb begin
        if (!is_data) a_r6_bad_nibble: assert (nib == NIB_BAD);
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pair_jk,
    input  logic             pair_tr,
    input  logic             idle_next,
    input  logic             is_data,
    input  logic [NIB_W-1:0] dec_nib,
    output rx_slot_t         slot
);
    rx_state_t st, st_nxt;
    rx_slot_t  slot_nxt, slot_q;

    always_comb begin
        st_nxt   = st;
        slot_nxt = '0;
        case (st)
            ST_IDLE: begin
                if (pair_jk) begin
                    slot_nxt.dv  = 1'b1;
                    slot_nxt.crs = 1'b1;
                    slot_nxt.nib = NIB_PRE;
                    st_nxt       = ST_SSD2;
                end
            end
            ST_SSD2: begin
                slot_nxt.dv  = 1'b1;
                slot_nxt.crs = 1'b1;
                slot_nxt.nib = NIB_PRE;
                if (idle_next) begin
                    slot_nxt.er = 1'b1;
                    st_nxt      = ST_IDLE;
                end else begin
                    st_nxt = ST_DATA;
                end
            end
            ST_DATA: begin
                if (pair_tr) begin
                    st_nxt = ST_IDLE;
                end else begin
                    slot_nxt.dv  = 1'b1;
                    slot_nxt.crs = 1'b1;
                    slot_nxt.nib = is_data ? dec_nib : NIB_BAD;
                    slot_nxt.er  = !is_data;
                    if (idle_next) begin
                        slot_nxt.er = 1'b1;
                        st_nxt      = ST_IDLE;
                    end
                end
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            slot_q <= '0;
        end else begin
            st     <= st_nxt;
            slot_q <= slot_nxt;
        end
    end

    assign slot = slot_q;

    a_r9_quiet_without_dv: assert property (@(posedge clk) disable iff (rst)
        !slot_q.dv |-> (slot_q.nib == '0) && !slot_q.er);
    a_r2_start_preamble: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_q.dv) |-> slot_q.nib == NIB_PRE && slot_q.crs);
    a_r2_second_preamble: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_q.dv) |=> slot_q.dv && slot_q.nib == NIB_PRE);
    a_r6_error_in_frame: assert property (@(posedge clk) disable iff (rst)
        slot_q.er |-> slot_q.dv);
    a_r4_carrier_tracks_dv: assert property (@(posedge clk) disable iff (rst)
        slot_q.crs == slot_q.dv);
endmodule

// File: rtl/rx_frame_det.sv
module rx_frame_det
    import rx_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CG_W-1:0]  code_in,
    input  logic             half_duplex,
    input  logic             tx_active,
    output logic             rx_dv,
    output logic [NIB_W-1:0] rxd,
    output logic             rx_er,
    output logic             crs,
    output logic             col
);
    logic [CG_W-1:0]  cg_cur;
    logic             pair_jk, pair_tr, idle_next, is_data;
    logic [NIB_W-1:0] dec_nib;
    rx_slot_t         slot;

    rx_cg_window u_window (
        .clk       (clk),
        .rst       (rst),
        .code_in   (code_in),
        .cg_cur    (cg_cur),
        .pair_jk   (pair_jk),
        .pair_tr   (pair_tr),
        .idle_next (idle_next)
    );

    rx_cg_decode u_decode (
        .cg      (cg_cur),
        .is_data (is_data),
        .nib     (dec_nib)
    );

    rx_frame_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pair_jk   (pair_jk),
        .pair_tr   (pair_tr),
        .idle_next (idle_next),
        .is_data   (is_data),
        .dec_nib   (dec_nib),
        .slot      (slot)
    );

    assign rx_dv = slot.dv;
    assign rxd   = slot.nib;
    assign rx_er = slot.er;
    assign crs   = slot.crs;
    assign col   = half_duplex && tx_active && slot.crs;

    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> !rx_dv && !crs && !rx_er);
endmodule

// File: tb/rx_frame_det_bench.sv
module rx_frame_det_bench;
    localparam time CLK_PERIOD = 40ns;
    localparam int  WATCHDOG   = 5000;

    typedef struct {
        logic       dv;
        logic [3:0] nib;
        logic       er;
        logic       crs;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] code_in = 5'b11111;
    logic       half_duplex = 1'b0;
    logic       tx_active = 1'b0;
    logic       rx_dv, rx_er, crs, col;
    logic [3:0] rxd;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cycles  = 0;
    bit   done    = 0;
    exp_t expq[$];

    localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                           R = 5'b00111, I = 5'b11111, BAD = 5'b00000;

    rx_frame_det u_rx_frame_det (
        .clk(clk), .rst(rst), .code_in(code_in), .half_duplex(half_duplex),
        .tx_active(tx_active), .rx_dv(rx_dv), .rxd(rxd), .rx_er(rx_er),
        .crs(crs), .col(col)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [4:0] enc(input logic [3:0] n);
        logic [4:0] tbl [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                                 5'b01010, 5'b01011, 5'b01110, 5'b01111,
                                 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                                 5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return tbl[n];
    endfunction

    task automatic put(input logic [4:0] cg, input logic dv, input logic [3:0] nib,
                       input logic er, input string tag);
        exp_t e;
        @(negedge clk);
        code_in = cg;
        e.dv = dv; e.nib = nib; e.er = er; e.crs = dv; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic idles(input int n, input string tag);
        for (int i = 0; i < n; i++) put(I, 1'b0, 4'h0, 1'b0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // monitor: compare each output slot against the oldest pending expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (expq.size() >= 2) begin
                exp_t e;
                logic ecol;
                e = expq.pop_front();
                ecol = e.crs && tx_active && half_duplex;
                n_tests++;
                if (rx_dv !== e.dv || rxd !== e.nib || rx_er !== e.er ||
                    crs !== e.crs || col !== ecol) begin
                    n_fail++;
                    $display("FAIL %s: dv/rxd/er/crs/col actual %b/%h/%b/%b/%b expected %b/%h/%b/%b/%b",
                             e.tag, rx_dv, rxd, rx_er, crs, col,
                             e.dv, e.nib, e.er, e.crs, ecol);
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
                finish_run();
            end
        end
    end

    task automatic check_quiet(input string tag);
        n_tests++;
        if (rx_dv !== 0 || rxd !== 0 || rx_er !== 0 || crs !== 0 || col !== 0) begin
            n_fail++;
            $display("FAIL %s: dv/rxd/er/crs/col actual %b/%h/%b/%b/%b expected 0/0/0/0/0",
                     tag, rx_dv, rxd, rx_er, crs, col);
        end
    endtask

    initial begin
        // R1: reset state, checked while reset is held
        half_duplex = 1'b1;
        tx_active   = 1'b1;
        code_in     = J;
        repeat (3) @(posedge clk);
        #1 check_quiet("R1");
        @(negedge clk);
        code_in     = I;
        half_duplex = 1'b0;
        tx_active   = 1'b0;
        rst = 1'b0;
        idles(3, "R1");

        // R2 R3 R4: normal frame, full duplex
        put(J, 1, 4'h5, 0, "R2");
        put(K, 1, 4'h5, 0, "R2");
        put(enc(4'h5), 1, 4'h5, 0, "R3");
        put(enc(4'hD), 1, 4'hD, 0, "R3");
        for (int n = 0; n < 16; n++) put(enc(n[3:0]), 1, n[3:0], 0, "R3");
        put(T, 0, 4'h0, 0, "R4");
        put(R, 0, 4'h0, 0, "R4");
        idles(2, "R4");

        // R7: stray groups outside a frame
        put(J, 0, 4'h0, 0, "R7");
        put(enc(4'h5), 0, 4'h0, 0, "R7");
        put(K, 0, 4'h0, 0, "R7");
        put(T, 0, 4'h0, 0, "R7");
        put(R, 0, 4'h0, 0, "R7");
        idles(2, "R7");

        // R6 + R8: invalid groups mid-frame, half duplex with transmitter active
        half_duplex = 1'b1;
        tx_active   = 1'b1;
        put(J, 1, 4'h5, 0, "R8");
        put(K, 1, 4'h5, 0, "R8");
        put(enc(4'h1), 1, 4'h1, 0, "R8");
        put(BAD, 1, 4'hE, 1, "R6");
        put(enc(4'h2), 1, 4'h2, 0, "R6");
        put(J, 1, 4'hE, 1, "R6");
        put(R, 1, 4'hE, 1, "R6");
        put(T, 1, 4'hE, 1, "R6");       // lone T (next is data)
        put(enc(4'h3), 1, 4'h3, 0, "R6");
        put(T, 0, 4'h0, 0, "R8");       // col falls with crs
        put(R, 0, 4'h0, 0, "R8");
        idles(2, "R8");

        // R8: half duplex but idle transmitter; full duplex with active transmitter
        tx_active = 1'b0;
        put(J, 1, 4'h5, 0, "R8");
        put(K, 1, 4'h5, 0, "R8");
        put(enc(4'h7), 1, 4'h7, 0, "R8");
        put(T, 0, 4'h0, 0, "R8");
        put(R, 0, 4'h0, 0, "R8");
        half_duplex = 1'b0;
        tx_active   = 1'b1;
        idles(1, "R8");
        put(J, 1, 4'h5, 0, "R8");
        put(K, 1, 4'h5, 0, "R8");
        put(T, 0, 4'h0, 0, "R8");
        put(R, 0, 4'h0, 0, "R8");
        tx_active = 1'b0;
        idles(2, "R8");

        // R5: idle abort after data
        put(J, 1, 4'h5, 0, "R5");
        put(K, 1, 4'h5, 0, "R5");
        put(enc(4'h1), 1, 4'h1, 0, "R5");
        put(enc(4'h2), 1, 4'h2, 1, "R5");
        idles(3, "R5");

        // R5: abort directly after K
        put(J, 1, 4'h5, 0, "R5");
        put(K, 1, 4'h5, 1, "R5");
        idles(2, "R5");

        // R5 + R6 same slot: invalid group followed by idle
        put(J, 1, 4'h5, 0, "R6");
        put(K, 1, 4'h5, 0, "R6");
        put(BAD, 1, 4'hE, 1, "R5");
        idles(2, "R9");

        // R5: T followed by idle (no R) is both invalid and an abort
        put(J, 1, 4'h5, 0, "R5");
        put(K, 1, 4'h5, 0, "R5");
        put(T, 1, 4'hE, 1, "R5");
        idles(2, "R9");

        // back-to-back frames: R directly followed by J/K
        put(J, 1, 4'h5, 0, "R2");
        put(K, 1, 4'h5, 0, "R2");
        put(T, 0, 4'h0, 0, "R4");
        put(R, 0, 4'h0, 0, "R4");
        put(J, 1, 4'h5, 0, "R2");
        put(K, 1, 4'h5, 0, "R2");
        put(enc(4'hA), 1, 4'hA, 0, "R3");
        put(T, 0, 4'h0, 0, "R4");
        put(R, 0, 4'h0, 0, "R4");
        idles(3, "R9");

        // R1: mid-frame reset returns to quiet
        put(J, 1, 4'h5, 0, "R1");
        put(K, 1, 4'h5, 0, "R1");
        @(negedge clk);
        rst = 1'b1;
        expq.delete();
        @(posedge clk);
        #1 check_quiet("R1");
        @(negedge clk);
        rst = 1'b0;
        code_in = enc(4'h4);
        @(posedge clk);
        #1 check_quiet("R1");
        @(posedge clk);
        #1 check_quiet("R7");

        finish_run();
    end
endmodule